// File: doc/BRIEF.md
# Shadow Return-Address Stack

This block keeps a protected duplicate of the return addresses a processor writes to its ordinary call stack. Each call event pushes its return address into a small internal array. Each return event pops that array. The address the program took from its ordinary stack is compared with the popped entry, and a difference raises a tamper violation. The violation reports both the address the shadow copy expected and the address that was supplied.

The array is indexed by a shadow pointer that grows upward. Supervisor code can read and write the pointer through a small register port, so an operating system can save and restore it across a context switch. User-mode code that touches the port gets a trap, and the pointer does not change. Decoding of call and return instructions, and the memory-backed stack itself, are outside the block.

Top module: `shadow_ret_stack`

## Requirements
- R1: A call event (`call_vld`=1) with the pointer below 16 stores `call_addr` at the pointer position and raises the pointer by one.
- R2: A return event (`ret_vld`=1) with the pointer above 0 lowers the pointer by one, whether or not the addresses match. If `ret_addr` differs from the most recently pushed address, `viol` is high for exactly the cycle after the event. In that cycle `viol_expect` holds the stored address and `viol_got` holds `ret_addr`. A matching return leaves `viol` low.
- R3: A call event with the pointer at 16 raises `ovf_fault` for the following cycle. The pointer and the stored entries stay unchanged.
- R4: A return event with the pointer at 0 raises `unf_fault` for the following cycle. `viol` stays low and the pointer stays at 0.
- R5: With `priv_sup`=1 and `csr_rd`=1, `csr_rdata` shows the current pointer in the same cycle, and no trap is raised.
- R6: With `priv_sup`=1 and `csr_wr`=1, the pointer takes `csr_wdata` from the next cycle on. A value above 16 is stored as 16.
- R7: With `priv_sup`=0, a read or a write on the register port raises `trap` for the following cycle, leaves the pointer unchanged and keeps `csr_rdata` at 0.
- R8: A call or return in the same cycle as a supervisor write is held for one cycle and then applied against the newly written pointer. Any new call or return offered in that following cycle is dropped.
- R9: If a call and a return arrive in the same cycle, the return is handled and the call is dropped.
- R10: A synchronous active-low reset clears the pointer to 0 and drives `viol`, `ovf_fault`, `unf_fault` and `trap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| call_vld | input | 1 | Call event this cycle |
| call_addr | input | 32 | Return address recorded by the call |
| ret_vld | input | 1 | Return event this cycle |
| ret_addr | input | 32 | Return address taken from the ordinary stack |
| priv_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| csr_rd | input | 1 | Read request for the shadow pointer |
| csr_wr | input | 1 | Write request for the shadow pointer |
| csr_wdata | input | 5 | New pointer value |
| csr_rdata | output | 5 | Pointer value on a supervisor read, else 0 |
| viol | output | 1 | Return-address mismatch pulse |
| viol_expect | output | 32 | Shadow address at the last mismatch |
| viol_got | output | 32 | Supplied address at the last mismatch |
| ovf_fault | output | 1 | Call refused because the storage is full |
| unf_fault | output | 1 | Return refused because the storage is empty |
| trap | output | 1 | User-mode access to the pointer port |

## Verification
Two cases can coincide. A supervisor pointer write can land in the same cycle as a call or return, and a call can arrive together with a return. The bench drives a write together with a call, then offers a second call in the replay cycle. It then reads the pointer back and pops the entries with matching addresses. This shows that the held address was stored at the new pointer position and that the second call left no trace. For the call-plus-return case, the bench confirms that the pointer drops rather than staying put and that no violation fires.

// File: rtl/ssk_pkg.sv
// Package: shared definitions for the shadow return-address stack.
// Assumes: one event at most is acted on per cycle.
package ssk_pkg;

    // Kind of stack event that is acted on in a cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2
    } ev_kind_t;

endpackage

// File: rtl/ssk_store.sv
// Module: ssk_store
// Holds the shadow return addresses in a small register array.
// Writes on a push; the top entry is read combinationally.
// Assumes: the controller never pushes at an index of DEPTH or above.
module ssk_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              push,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] mem [DEPTH];

    // Record the pushed return address
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the entry below the pointer (top of stack)
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/ssk_ctrl.sv
// Module: ssk_ctrl
// Owns the shadow pointer. It arbitrates call and return events, applies
// privileged pointer writes and holds any event that collides with such a write.
// Assumes: priv_sup is valid in every cycle that has a port access.
module ssk_ctrl
    import ssk_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_vld,
    input  logic [ADDR_W-1:0] call_addr,
    input  logic              ret_vld,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              priv_sup,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [PTR_W-1:0]  csr_wdata,
    output logic [PTR_W-1:0]  csr_rdata,
    output logic              push,
    output logic              pop,
    output logic              ovf_ev,
    output logic              unf_ev,
    output logic              trap_ev,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    logic [PTR_W-1:0]  ptr;
    ev_kind_t          pend_kind;
    logic [ADDR_W-1:0] pend_addr;
    ev_kind_t          live_kind;
    logic [ADDR_W-1:0] live_addr;
    ev_kind_t          cur_kind;
    logic              sup_wr;
    logic [PTR_W-1:0]  wr_val;

    // Pick the live event; a return outranks a call
    always_comb begin
        if (ret_vld) begin
            live_kind = EV_RET;
            live_addr = ret_addr;
        end else if (call_vld) begin
            live_kind = EV_CALL;
            live_addr = call_addr;
        end else begin
            live_kind = EV_NONE;
            live_addr = call_addr;
        end
    end

    // A held event replaces whatever arrives live in its replay cycle
    always_comb begin
        if (pend_kind != EV_NONE) begin
            cur_kind = pend_kind;
            ev_addr  = pend_addr;
        end else begin
            cur_kind = live_kind;
            ev_addr  = live_addr;
        end
    end

    // Decode the event against the pointer and the port access
    always_comb begin
        sup_wr  = csr_wr & priv_sup;
        trap_ev = ~priv_sup & (csr_rd | csr_wr);
        wr_val  = (csr_wdata > FULL) ? FULL : csr_wdata;
        push    = ~sup_wr & (cur_kind == EV_CALL) & (ptr < FULL);
        ovf_ev  = ~sup_wr & (cur_kind == EV_CALL) & (ptr >= FULL);
        pop     = ~sup_wr & (cur_kind == EV_RET) & (ptr != '0);
        unf_ev  = ~sup_wr & (cur_kind == EV_RET) & (ptr == '0);
        wr_idx  = ptr[IDX_W-1:0];
        rd_idx  = ptr[IDX_W-1:0] - 1'b1;
    end

    // Supervisor read shows the pointer; anything else reads 0
    assign csr_rdata = (priv_sup & csr_rd) ? ptr : '0;

    // Update the pointer and the one-deep hold slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            pend_kind <= EV_NONE;
            pend_addr <= '0;
        end else if (sup_wr) begin
            ptr       <= wr_val;
            pend_kind <= cur_kind;
            pend_addr <= ev_addr;
        end else begin
            pend_kind <= EV_NONE;
            if (push) begin
                ptr <= ptr + 1'b1;
            end else if (pop) begin
                ptr <= ptr - 1'b1;
            end
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= FULL); // R6
    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ptr == $past(ptr) + 1'b1); // R1
    AST_POP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> ptr == $past(ptr) - 1'b1); // R2
    AST_OVF_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> $stable(ptr)); // R3
    AST_UNF_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev |=> ptr == '0); // R4
    AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !priv_sup && cur_kind == EV_NONE) |=> $stable(ptr)); // R7
    AST_USER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_sup |-> csr_rdata == '0); // R7
    AST_SUP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_wr && csr_wdata <= FULL) |=> ptr == $past(csr_wdata)); // R6

endmodule

// File: rtl/ssk_report.sv
// Module: ssk_report
// Registers the fault pulses and captures the addresses of a mismatch.
// Assumes: pop, ovf_ev and unf_ev are mutually exclusive from the controller.
module ssk_report #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              ovf_ev,
    input  logic              unf_ev,
    input  logic              trap_ev,
    input  logic [ADDR_W-1:0] top_addr,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_expect,
    output logic [ADDR_W-1:0] viol_got,
    output logic              ovf_fault,
    output logic              unf_fault,
    output logic              trap
);

    logic mismatch;

    // A pop whose supplied address differs from the shadow copy
    assign mismatch = pop & (top_addr != ev_addr);

    // Register one-cycle fault pulses and mismatch addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol        <= 1'b0;
            viol_expect <= '0;
            viol_got    <= '0;
            ovf_fault   <= 1'b0;
            unf_fault   <= 1'b0;
            trap        <= 1'b0;
        end else begin
            viol      <= mismatch;
            ovf_fault <= ovf_ev;
            unf_fault <= unf_ev;
            trap      <= trap_ev;
            if (mismatch) begin
                viol_expect <= top_addr;
                viol_got    <= ev_addr;
            end
        end
    end

    AST_ONE_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol, ovf_fault, unf_fault})); // R9
    AST_VIOL_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(pop)); // R2
    AST_UNF_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev |=> !viol); // R4
    AST_TRAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ev |=> trap); // R7

endmodule

// File: rtl/shadow_ret_stack.sv
// Module: shadow_ret_stack (top)
// Shadow return-address stack with a privileged pointer port.
// Assumes: call and return events come from a decoder, one cycle each.
module shadow_ret_stack #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_vld,
    input  logic [ADDR_W-1:0] call_addr,
    input  logic              ret_vld,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              priv_sup,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [PTR_W-1:0]  csr_wdata,
    output logic [PTR_W-1:0]  csr_rdata,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_expect,
    output logic [ADDR_W-1:0] viol_got,
    output logic              ovf_fault,
    output logic              unf_fault,
    output logic              trap
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              push;
    logic              pop;
    logic              ovf_ev;
    logic              unf_ev;
    logic              trap_ev;
    logic [ADDR_W-1:0] ev_addr;
    logic [ADDR_W-1:0] top_addr;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    ssk_ctrl #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .PTR_W (PTR_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_vld (call_vld),
        .call_addr(call_addr),
        .ret_vld  (ret_vld),
        .ret_addr (ret_addr),
        .priv_sup (priv_sup),
        .csr_rd   (csr_rd),
        .csr_wr   (csr_wr),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .push     (push),
        .pop      (pop),
        .ovf_ev   (ovf_ev),
        .unf_ev   (unf_ev),
        .trap_ev  (trap_ev),
        .ev_addr  (ev_addr),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx)
    );

    ssk_store #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .push   (push),
        .wr_idx (wr_idx),
        .wr_data(ev_addr),
        .rd_idx (rd_idx),
        .rd_data(top_addr)
    );

    ssk_report #(
        .ADDR_W(ADDR_W)
    ) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (pop),
        .ovf_ev     (ovf_ev),
        .unf_ev     (unf_ev),
        .trap_ev    (trap_ev),
        .top_addr   (top_addr),
        .ev_addr    (ev_addr),
        .viol       (viol),
        .viol_expect(viol_expect),
        .viol_got   (viol_got),
        .ovf_fault  (ovf_fault),
        .unf_fault  (unf_fault),
        .trap       (trap)
    );

endmodule

// File: tb/test_shadow_ret_stack.sv
`timescale 1ns/1ps
// Bench for shadow_ret_stack: a vector table, then directed corner cases.
module test_shadow_ret_stack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        call_vld, ret_vld;
    logic [31:0] call_addr, ret_addr;
    logic        priv_sup, csr_rd, csr_wr;
    logic [4:0]  csr_wdata;
    logic [4:0]  csr_rdata;
    logic        viol, ovf_fault, unf_fault, trap;
    logic [31:0] viol_expect, viol_got;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shadow_ret_stack i_shadow_ret_stack (
        .clk(clk), .rst_n(rst_n),
        .call_vld(call_vld), .call_addr(call_addr),
        .ret_vld(ret_vld), .ret_addr(ret_addr),
        .priv_sup(priv_sup), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .viol(viol), .viol_expect(viol_expect), .viol_got(viol_got),
        .ovf_fault(ovf_fault), .unf_fault(unf_fault), .trap(trap)
    );

    // Vector: kind (1 call, 2 return), address, expected viol/ovf/unf, pointer after
    typedef struct packed {
        logic [1:0]  k;
        logic [31:0] a;
        logic        v;
        logic        o;
        logic        u;
        logic [4:0]  p;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{2'd1, 32'h100, 1'b0, 1'b0, 1'b0, 5'd1},
        '{2'd1, 32'h200, 1'b0, 1'b0, 1'b0, 5'd2},
        '{2'd2, 32'h200, 1'b0, 1'b0, 1'b0, 5'd1},
        '{2'd2, 32'h999, 1'b1, 1'b0, 1'b0, 5'd0},
        '{2'd2, 32'h001, 1'b0, 1'b0, 1'b1, 5'd0},
        '{2'd1, 32'h300, 1'b0, 1'b0, 1'b0, 5'd1},
        '{2'd1, 32'h400, 1'b0, 1'b0, 1'b0, 5'd2},
        '{2'd2, 32'h400, 1'b0, 1'b0, 1'b0, 5'd1},
        '{2'd2, 32'h300, 1'b0, 1'b0, 1'b0, 5'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle from a negative edge and return at the next negative edge
    task automatic cyc(input bit c, input bit r, input logic [31:0] a,
                       input bit sup, input bit rd, input bit wr, input logic [4:0] wd);
        call_vld  = c;
        ret_vld   = r;
        call_addr = a;
        ret_addr  = a;
        priv_sup  = sup;
        csr_rd    = rd;
        csr_wr    = wr;
        csr_wdata = wd;
        @(negedge clk);
    endtask

    task automatic do_call(input logic [31:0] a); cyc(1, 0, a, 1, 1, 0, 5'd0); endtask
    task automatic do_ret(input logic [31:0] a);  cyc(0, 1, a, 1, 1, 0, 5'd0); endtask
    task automatic do_wr(input logic [4:0] wd);   cyc(0, 0, 32'h0, 1, 1, 1, wd); endtask
    task automatic do_idle();                     cyc(0, 0, 32'h0, 1, 1, 0, 5'd0); endtask

    task automatic chk_quiet(input string req);
        chk(viol == 1'b0, req, "viol", 32'(viol), 32'd0);
        chk(ovf_fault == 1'b0, req, "ovf_fault", 32'(ovf_fault), 32'd0);
        chk(unf_fault == 1'b0, req, "unf_fault", 32'(unf_fault), 32'd0);
        chk(trap == 1'b0, req, "trap", 32'(trap), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cyc(0, 0, 32'h0, 1, 1, 0, 5'd0);
        cyc(0, 0, 32'h0, 1, 1, 0, 5'd0);
        rst_n = 1'b1;
        // R10: reset state
        chk(csr_rdata == 5'd0, "R10", "pointer after reset", 32'(csr_rdata), 32'd0);
        chk_quiet("R10");

        // Table walk: R1 calls, R2 returns, R4 empty return
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            cyc(TBL[i].k == 2'd1, TBL[i].k == 2'd2, TBL[i].a, 1, 1, 0, 5'd0);
            tag = (TBL[i].k == 2'd1) ? "R1" : (TBL[i].u ? "R4" : "R2");
            chk(viol == TBL[i].v, tag, $sformatf("row %0d viol", i), 32'(viol), 32'(TBL[i].v));
            chk(ovf_fault == TBL[i].o, tag, $sformatf("row %0d ovf", i), 32'(ovf_fault), 32'(TBL[i].o));
            chk(unf_fault == TBL[i].u, tag, $sformatf("row %0d unf", i), 32'(unf_fault), 32'(TBL[i].u));
            chk(csr_rdata == TBL[i].p, tag, $sformatf("row %0d pointer", i), 32'(csr_rdata), 32'(TBL[i].p));
        end

        // R2: mismatch reports both addresses, then the pulse ends
        do_call(32'hA);
        do_ret(32'hB);
        chk(viol == 1'b1, "R2", "viol on mismatch", 32'(viol), 32'd1);
        chk(viol_expect == 32'hA, "R2", "viol_expect", viol_expect, 32'hA);
        chk(viol_got == 32'hB, "R2", "viol_got", viol_got, 32'hB);
        do_idle();
        chk(viol == 1'b0, "R2", "viol one cycle only", 32'(viol), 32'd0);

        // R6: write clamps above depth; plain write lands next cycle
        do_wr(5'd31);
        chk(csr_rdata == 5'd16, "R6", "clamped write", 32'(csr_rdata), 32'd16);
        do_wr(5'd3);
        chk(csr_rdata == 5'd3, "R6", "written pointer", 32'(csr_rdata), 32'd3);

        // R3: call at full storage refused, top entry untouched
        do_wr(5'd15);
        do_call(32'hF0);
        chk(csr_rdata == 5'd16, "R3", "pointer at full", 32'(csr_rdata), 32'd16);
        do_call(32'hEE);
        chk(ovf_fault == 1'b1, "R3", "ovf_fault", 32'(ovf_fault), 32'd1);
        chk(csr_rdata == 5'd16, "R3", "pointer kept", 32'(csr_rdata), 32'd16);
        do_ret(32'hF0);
        chk(viol == 1'b0, "R3", "top entry kept", 32'(viol), 32'd0);
        chk(csr_rdata == 5'd15, "R3", "pointer after pop", 32'(csr_rdata), 32'd15);

        // R7: user write and read trap; R5: supervisor read does not
        cyc(0, 0, 32'h0, 0, 0, 1, 5'd7);
        chk(trap == 1'b1, "R7", "trap on user write", 32'(trap), 32'd1);
        cyc(0, 0, 32'h0, 0, 1, 0, 5'd0);
        chk(trap == 1'b1, "R7", "trap on user read", 32'(trap), 32'd1);
        chk(csr_rdata == 5'd0, "R7", "user read data", 32'(csr_rdata), 32'd0);
        do_idle();
        chk(trap == 1'b0, "R5", "no trap on supervisor read", 32'(trap), 32'd0);
        chk(csr_rdata == 5'd15, "R7", "pointer unchanged", 32'(csr_rdata), 32'd15);

        // R8: call held across a write, replay-cycle call dropped
        do_wr(5'd0);
        do_call(32'h10);
        do_call(32'h20);
        cyc(1, 0, 32'h55, 1, 1, 1, 5'd1);
        do_call(32'h77);
        do_idle();
        chk(csr_rdata == 5'd2, "R8", "pointer after held call", 32'(csr_rdata), 32'd2);
        do_ret(32'h55);
        chk(viol == 1'b0, "R8", "held address stored", 32'(viol), 32'd0);
        do_ret(32'h10);
        chk(viol == 1'b0, "R8", "lower entry intact", 32'(viol), 32'd0);
        chk(csr_rdata == 5'd0, "R8", "pointer drained", 32'(csr_rdata), 32'd0);

        // R9: call together with return, return wins
        do_call(32'h30);
        cyc(1, 1, 32'h30, 1, 1, 0, 5'd0);
        chk(viol == 1'b0, "R9", "no viol", 32'(viol), 32'd0);
        chk(csr_rdata == 5'd0, "R9", "call dropped", 32'(csr_rdata), 32'd0);

        // R10: reset in mid-run clears pointer and faults
        do_call(32'h1);
        do_call(32'h2);
        rst_n = 1'b0;
        cyc(0, 1, 32'h9, 1, 1, 0, 5'd0);
        rst_n = 1'b1;
        do_idle();
        chk(csr_rdata == 5'd0, "R10", "pointer after reset", 32'(csr_rdata), 32'd0);
        chk_quiet("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule